// File: doc/BRIEF.md
# Stride-Banded Longest-Prefix Lookup Pipeline

This block finds the longest stored prefix that matches a 32-bit IPv4 destination address and returns a pointer into a next-hop table held elsewhere. The address is cut into four 8-bit strides. Each stride has its own level stage. A level keeps only the subtrees that actually hold prefixes. Each subtree is a tag, which is the address bits that lead into it, plus a bitmap that marks the prefixes inside its 8-bit band, plus a base pointer.

Lookups enter through a valid/ready port and move one level per clock. Every level keeps the longer of the result it received and its own match. The fourth stage therefore presents the longest match overall, or raises a default-route flag when nothing matched. Software loads a subtree entry through a single-cycle write port that addresses one level and one slot.

Top module: `stride_lpm`

## Requirements
- R1: When out_ready is held high, an address accepted on a clock edge has its result on the outputs after exactly four clock edges, and a new address is accepted on every cycle.
- R2: Level L (L = 1..4) uses only address bits [31 : 32−8L]. An entry's tag is compared with the leading 8(L−1) address bits, left-aligned in the 24-bit tag field. Tag bits below those leading bits are ignored.
- R3: Level L reports only prefix lengths in the range 8(L−1)+1 to 8L.
- R4: A level whose valid entries all have tags that differ from the address contributes no match.
- R5: In an entry bitmap, bit (2^n − 2 + v) marks the prefix of length n (1..8) within the stride whose n leading stride bits have value v. The level's match is the longest marked prefix on the address path.
- R6: On a match, out_index equals the entry's base plus the heap node number (2^n − 1 + v), taken modulo 2^16.
- R7: Among the levels, the match from the highest-numbered level that found one becomes the result.
- R8: When no level matches, out_default is 1, out_hit is 0, and out_len and out_index are 0.
- R9: While out_valid is high and out_ready is low, the outputs hold their values and in_ready is low.
- R10: A write with wr_en, wr_level = L−1 and wr_slot replaces that whole entry in one cycle. With wr_keep = 0 the entry is removed. Lookups accepted after the write edge see the new contents.
- R11: After reset, out_valid is low and every level is empty, so a lookup returns the default route.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Lookup request valid |
| in_ready | output | 1 | Lookup request accepted when high |
| in_addr | input | 32 | Destination address to search |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_hit | output | 1 | A prefix matched |
| out_default | output | 1 | No prefix matched; use the default route |
| out_len | output | 6 | Length of the winning prefix |
| out_index | output | 16 | Pointer into the next-hop table |
| wr_en | input | 1 | Table write strobe |
| wr_level | input | 2 | Level to write, 0 for level 1 |
| wr_slot | input | 2 | Entry slot within the level |
| wr_keep | input | 1 | 1 stores the entry, 0 removes it |
| wr_tag | input | 24 | Leading address bits, left-aligned |
| wr_bitmap | input | 510 | Prefix bitmap of the subtree |
| wr_base | input | 16 | Base pointer of the subtree |

## Verification
Directed addresses are chosen so that each one stops at a different point in the search:
- the empty table;
- a short and a long prefix nested in one stride, which separates longest-in-level from first-found;
- a tag padded with junk low bits, which exposes over-wide tag compares;
- an address whose level-2 tag misses, so the search falls back to level 1;
- an exact /32 beside a /16 on the same path, which exposes a wrong choice between levels.

Entry removal and rewrites confirm that results follow the current table. A back-to-back burst measures latency and throughput, and a held-off consumer shows whether results stay stable. A long mix of random addresses near stored prefixes, with random backpressure and random rewrites between batches, is compared result by result against a behavioural model.

// File: rtl/slpm_pkg.sv
package slpm_pkg;

   // bitmap bit of the prefix of length len whose leading bits are val
   function automatic int unsigned bmp_pos(int unsigned len, int unsigned val);
      return (32'd1 << len) - 32'd2 + val;
   endfunction

   // heap node number of the same prefix (root of the stride is node 0)
   function automatic int unsigned heap_node(int unsigned len, int unsigned val);
      return (32'd1 << len) - 32'd1 + val;
   endfunction

endpackage

// File: rtl/slpm_bitmap_scan.sv
module slpm_bitmap_scan
   import slpm_pkg::*;
#(
   parameter int STRIDE = 8,
   localparam int BMP_W = (1 << (STRIDE + 1)) - 2,
   localparam int SL_W  = $clog2(STRIDE + 1)
)(
   input  logic [BMP_W-1:0]  bmp,
   input  logic [STRIDE-1:0] chunk,
   output logic              hit,
   output logic [SL_W-1:0]   len,
   output logic [STRIDE:0]   node
);

   // ascending walk: a longer marked prefix overwrites a shorter one
   always_comb begin
      hit  = 1'b0;
      len  = '0;
      node = '0;
      for (int l = 1; l <= STRIDE; l++) begin
         if (bmp[bmp_pos(l, 32'(chunk) >> (STRIDE - l))]) begin
            hit  = 1'b1;
            len  = SL_W'(l);
            node = (STRIDE + 1)'(heap_node(l, 32'(chunk) >> (STRIDE - l)));
         end
      end
   end

endmodule

// File: rtl/slpm_subtree_table.sv
module slpm_subtree_table #(
   parameter int TAG_W     = 24,
   parameter int MASK_BITS = 0,
   parameter int BMP_W     = 510,
   parameter int PTR_W     = 16,
   parameter int ENTRIES   = 4,
   localparam int SLOT_W   = $clog2(ENTRIES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic              wr_keep,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [BMP_W-1:0]  wr_bmp,
   input  logic [PTR_W-1:0]  wr_base,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [BMP_W-1:0]  lk_bmp,
   output logic [PTR_W-1:0]  lk_base
);

   localparam logic [TAG_W-1:0] MASK = {TAG_W{1'b1}} << (TAG_W - MASK_BITS);

   logic [ENTRIES-1:0] vld_q;
   logic [ENTRIES-1:0] match;
   logic [BMP_W-1:0]   bmp_q  [ENTRIES];
   logic [PTR_W-1:0]   base_q [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) vld_q <= '0;
      else if (wr_en) vld_q[wr_slot] <= wr_keep;
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         bmp_q[wr_slot]  <= wr_bmp;
         base_q[wr_slot] <= wr_base;
      end
   end

   generate
      if (MASK_BITS == 0) begin : g_root
         // the first level has a single subtree: no leading bits to compare
         logic unused_tag;
         assign unused_tag = ^{lk_tag, wr_tag};
         assign match = '1;
      end else begin : g_tagged
         logic [TAG_W-1:0] tag_q [ENTRIES];
         always_ff @(posedge clk) begin
            if (wr_en) tag_q[wr_slot] <= wr_tag & MASK;
         end
         for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
            assign match[e] = (tag_q[e] == (lk_tag & MASK));
         end
      end
   endgenerate

   // lowest matching slot wins
   always_comb begin
      lk_hit  = 1'b0;
      lk_bmp  = '0;
      lk_base = '0;
      for (int e = ENTRIES - 1; e >= 0; e--) begin
         if (vld_q[e] && match[e]) begin
            lk_hit  = 1'b1;
            lk_bmp  = bmp_q[e];
            lk_base = base_q[e];
         end
      end
   end

endmodule

// File: rtl/slpm_level.sv
module slpm_level #(
   parameter int ADDR_W  = 32,
   parameter int STRIDE  = 8,
   parameter int ENTRIES = 4,
   parameter int PTR_W   = 16,
   parameter int LVL     = 1,
   localparam int TAG_W  = ADDR_W - STRIDE,
   localparam int BMP_W  = (1 << (STRIDE + 1)) - 2,
   localparam int LEN_W  = $clog2(ADDR_W + 1),
   localparam int SL_W   = $clog2(STRIDE + 1),
   localparam int SLOT_W = $clog2(ENTRIES),
   localparam int LO     = (LVL - 1) * STRIDE,
   localparam int HI     = LVL * STRIDE
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              adv,
   input  logic              in_vld,
   input  logic [ADDR_W-1:0] in_addr,
   input  logic              in_hit,
   input  logic [LEN_W-1:0]  in_len,
   input  logic [PTR_W-1:0]  in_idx,
   input  logic              wr_en,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic              wr_keep,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [BMP_W-1:0]  wr_bmp,
   input  logic [PTR_W-1:0]  wr_base,
   output logic              out_vld,
   output logic [ADDR_W-1:0] out_addr,
   output logic              out_hit,
   output logic [LEN_W-1:0]  out_len,
   output logic [PTR_W-1:0]  out_idx
);

   logic              tbl_hit;
   logic [BMP_W-1:0]  tbl_bmp;
   logic [PTR_W-1:0]  tbl_base;
   logic              scan_hit;
   logic [SL_W-1:0]   scan_len;
   logic [STRIDE:0]   scan_node;
   logic              own_hit;
   logic [STRIDE-1:0] chunk;

   assign chunk = in_addr[ADDR_W - 1 - LO -: STRIDE];

   slpm_subtree_table #(
      .TAG_W(TAG_W), .MASK_BITS(LO), .BMP_W(BMP_W),
      .PTR_W(PTR_W), .ENTRIES(ENTRIES)
   ) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_slot(wr_slot), .wr_keep(wr_keep),
      .wr_tag(wr_tag), .wr_bmp(wr_bmp), .wr_base(wr_base),
      .lk_tag(in_addr[ADDR_W-1 -: TAG_W]),
      .lk_hit(tbl_hit), .lk_bmp(tbl_bmp), .lk_base(tbl_base)
   );

   slpm_bitmap_scan #(.STRIDE(STRIDE)) u_scan (
      .bmp(tbl_bmp), .chunk(chunk),
      .hit(scan_hit), .len(scan_len), .node(scan_node)
   );

   assign own_hit = tbl_hit && scan_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_vld  <= 1'b0;
         out_addr <= '0;
         out_hit  <= 1'b0;
         out_len  <= '0;
         out_idx  <= '0;
      end else if (adv) begin
         out_vld  <= in_vld;
         out_addr <= in_addr;
         out_hit  <= in_hit || own_hit;
         out_len  <= own_hit ? LEN_W'(LO) + LEN_W'(scan_len) : in_len;
         out_idx  <= own_hit ? tbl_base + PTR_W'(scan_node) : in_idx;
      end
   end

   // R3: a match made here stays inside this level's band
   assert_band_R3: assert property (@(posedge clk) disable iff (!rst_n)
      adv && in_vld && own_hit |=> out_len > LEN_W'(LO) && out_len <= LEN_W'(HI));

   // R7: a stage never shortens a match it received
   assert_no_shorten_R7: assert property (@(posedge clk) disable iff (!rst_n)
      adv && in_vld && in_hit |=> out_hit && out_len >= $past(in_len));

endmodule

// File: rtl/stride_lpm.sv
module stride_lpm #(
   parameter int ADDR_W  = 32,
   parameter int STRIDE  = 8,
   parameter int ENTRIES = 4,
   parameter int PTR_W   = 16,
   localparam int LEVELS = ADDR_W / STRIDE,
   localparam int TAG_W  = ADDR_W - STRIDE,
   localparam int BMP_W  = (1 << (STRIDE + 1)) - 2,
   localparam int LEN_W  = $clog2(ADDR_W + 1),
   localparam int LVL_W  = $clog2(LEVELS),
   localparam int SLOT_W = $clog2(ENTRIES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_addr,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_hit,
   output logic              out_default,
   output logic [LEN_W-1:0]  out_len,
   output logic [PTR_W-1:0]  out_index,
   input  logic              wr_en,
   input  logic [LVL_W-1:0]  wr_level,
   input  logic [SLOT_W-1:0] wr_slot,
   input  logic              wr_keep,
   input  logic [TAG_W-1:0]  wr_tag,
   input  logic [BMP_W-1:0]  wr_bitmap,
   input  logic [PTR_W-1:0]  wr_base
);

   if (ADDR_W % STRIDE != 0) begin : g_chk_stride
      $error("ADDR_W must be a multiple of STRIDE");
   end
   if (LEVELS < 2) begin : g_chk_levels
      $error("at least two levels are required");
   end
   if (ENTRIES < 2 || (ENTRIES & (ENTRIES - 1)) != 0) begin : g_chk_entries
      $error("ENTRIES must be a power of two, at least 2");
   end
   if (PTR_W < STRIDE + 1) begin : g_chk_ptr
      $error("PTR_W too narrow for a heap node number");
   end

   logic              vld_s  [LEVELS+1];
   logic [ADDR_W-1:0] addr_s [LEVELS+1];
   logic              hit_s  [LEVELS+1];
   logic [LEN_W-1:0]  len_s  [LEVELS+1];
   logic [PTR_W-1:0]  idx_s  [LEVELS+1];
   logic              adv;

   // one global advance: every stage moves when the last one can drain
   assign adv      = !vld_s[LEVELS] || out_ready;
   assign in_ready = adv;

   assign vld_s[0]  = in_valid;
   assign addr_s[0] = in_addr;
   assign hit_s[0]  = 1'b0;
   assign len_s[0]  = '0;
   assign idx_s[0]  = '0;

   generate
      for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
         slpm_level #(
            .ADDR_W(ADDR_W), .STRIDE(STRIDE), .ENTRIES(ENTRIES),
            .PTR_W(PTR_W), .LVL(g + 1)
         ) u_level (
            .clk(clk), .rst_n(rst_n), .adv(adv),
            .in_vld(vld_s[g]), .in_addr(addr_s[g]), .in_hit(hit_s[g]),
            .in_len(len_s[g]), .in_idx(idx_s[g]),
            .wr_en(wr_en && (wr_level == LVL_W'(g))),
            .wr_slot(wr_slot), .wr_keep(wr_keep), .wr_tag(wr_tag),
            .wr_bmp(wr_bitmap), .wr_base(wr_base),
            .out_vld(vld_s[g+1]), .out_addr(addr_s[g+1]), .out_hit(hit_s[g+1]),
            .out_len(len_s[g+1]), .out_idx(idx_s[g+1])
         );
      end
   endgenerate

   logic unused_addr;
   assign unused_addr = ^addr_s[LEVELS];

   assign out_valid   = vld_s[LEVELS];
   assign out_hit     = hit_s[LEVELS];
   assign out_default = vld_s[LEVELS] && !hit_s[LEVELS];
   assign out_len     = len_s[LEVELS];
   assign out_index   = idx_s[LEVELS];

   // R9: a held result does not change until taken
   assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_hit)
                                 && $stable(out_len) && $stable(out_index));

   // R8: a default-route result carries no length and no pointer
   assert_default_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_default |-> !out_hit && out_len == '0 && out_index == '0);

endmodule

// File: tb/stride_lpm_bench.sv
module stride_lpm_bench;

   localparam int CLK_PERIOD = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic          in_ready;
   logic [31:0]   in_addr = '0;
   logic          out_valid;
   logic          out_ready = 1'b1;
   logic          out_hit;
   logic          out_default;
   logic [5:0]    out_len;
   logic [15:0]   out_index;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_level = '0;
   logic [1:0]    wr_slot = '0;
   logic          wr_keep = 1'b0;
   logic [23:0]   wr_tag = '0;
   logic [509:0]  wr_bitmap = '0;
   logic [15:0]   wr_base = '0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   stride_lpm u_stride_lpm (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr),
      .out_valid(out_valid), .out_ready(out_ready), .out_hit(out_hit),
      .out_default(out_default), .out_len(out_len), .out_index(out_index),
      .wr_en(wr_en), .wr_level(wr_level), .wr_slot(wr_slot), .wr_keep(wr_keep),
      .wr_tag(wr_tag), .wr_bitmap(wr_bitmap), .wr_base(wr_base)
   );

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;
   int cyc      = 0;
   bit rr_mode  = 0;
   bit lat_mode = 0;
   string cur_req = "R11";

   // behavioural table model
   bit           m_vld  [4][4];
   logic [23:0]  m_tag  [4][4];
   logic [509:0] m_bmp  [4][4];
   int           m_base [4][4];

   // expected results in acceptance order
   bit    q_hit [$];
   int    q_len [$];
   int    q_idx [$];
   int    q_cyc [$];
   string q_req [$];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [509:0] pfx(input int len, input int v);
      logic [509:0] b = '0;
      b[(1 << len) - 2 + v] = 1'b1;
      return b;
   endfunction

   task automatic model(input logic [31:0] a, output bit h, output int ln, output int ix);
      h = 0; ln = 0; ix = 0;
      for (int lv = 1; lv <= 4; lv++) begin
         int lead;
         int slot;
         lead = (lv - 1) * 8;
         slot = -1;
         for (int s = 3; s >= 0; s--) begin
            if (m_vld[lv-1][s] &&
                (lead == 0 || (32'(m_tag[lv-1][s]) >> (24 - lead)) == (a >> (32 - lead))))
               slot = s;
         end
         if (slot >= 0) begin
            int ch;
            ch = int'((a >> (32 - lv * 8)) & 32'hFF);
            for (int l = 8; l >= 1; l--) begin
               int v;
               v = ch >> (8 - l);
               if (m_bmp[lv-1][slot][(1 << l) - 2 + v]) begin
                  h  = 1;
                  ln = lead + l;
                  ix = (m_base[lv-1][slot] + (1 << l) - 1 + v) & 16'hFFFF;
                  break;
               end
            end
         end
      end
   endtask

   // monitor: all inputs settle 2 time units after a rising edge
   bit          prev_stall = 0;
   bit          prev_hit;
   logic [5:0]  prev_len;
   logic [15:0] prev_idx;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         cyc++;
         if (prev_stall) begin
            chk(out_valid == 1'b1, "R9", "valid held", out_valid, 1);
            chk(out_hit == prev_hit && out_len == prev_len && out_index == prev_idx,
                "R9", "result held", out_index, prev_idx);
         end
         if (out_valid && !out_ready)
            chk(in_ready == 1'b0, "R9", "in_ready low under stall", in_ready, 0);
         if (in_valid && in_ready) begin
            bit h; int ln; int ix;
            model(in_addr, h, ln, ix);
            q_hit.push_back(h); q_len.push_back(ln); q_idx.push_back(ix);
            q_cyc.push_back(cyc); q_req.push_back(cur_req);
         end
         if (out_valid && out_ready) begin
            if (q_hit.size() == 0) begin
               chk(0, "R1", "unexpected result", 1, 0);
            end else begin
               bit eh; int el; int ei; int ec; string er;
               eh = q_hit.pop_front(); el = q_len.pop_front(); ei = q_idx.pop_front();
               ec = q_cyc.pop_front(); er = q_req.pop_front();
               chk(out_hit == eh && out_default == !eh, er, "hit", out_hit, eh);
               chk(int'(out_len) == el, er, "len", out_len, el);
               chk(int'(out_index) == ei, er, "index", out_index, ei);
               if (lat_mode) chk(cyc - ec == 4, "R1", "latency", cyc - ec, 4);
            end
         end
         prev_stall = out_valid && !out_ready;
         prev_hit = out_hit; prev_len = out_len; prev_idx = out_index;
      end
   end

   task automatic next_cycle();
      @(posedge clk);
      #2;
      if (rr_mode) out_ready = ($urandom_range(2) != 0);
   endtask

   task automatic wr(input int lv, input int s, input bit keep, input logic [23:0] tag,
                     input logic [509:0] bm, input int base);
      wr_en = 1; wr_level = 2'(lv - 1); wr_slot = 2'(s); wr_keep = keep;
      wr_tag = tag; wr_bitmap = bm; wr_base = 16'(base);
      m_vld[lv-1][s] = keep; m_tag[lv-1][s] = tag;
      m_bmp[lv-1][s] = bm; m_base[lv-1][s] = base;
      next_cycle();
      wr_en = 0;
   endtask

   task automatic send(input logic [31:0] a, input string req);
      in_addr = a; in_valid = 1; cur_req = req;
      forever begin
         bit acc;
         @(negedge clk);
         acc = in_ready;
         next_cycle();
         if (acc) break;
      end
      in_valid = 0;
   endtask

   task automatic drain();
      int n = 0;
      in_valid = 0;
      while ((q_hit.size() != 0 || out_valid) && n < 400) begin
         next_cycle();
         n++;
      end
      chk(q_hit.size() == 0, "R1", "all results returned", q_hit.size(), 0);
   endtask

   logic [31:0] bases [4] = '{32'h0A0105_00, 32'h0A0107_00, 32'h0B0000_00, 32'h0C0000_00};

   initial begin
      for (int l = 0; l < 4; l++)
         for (int s = 0; s < 4; s++) begin
            m_vld[l][s] = 0; m_tag[l][s] = '0; m_bmp[l][s] = '0; m_base[l][s] = 0;
         end
      repeat (3) @(negedge clk);
      chk(out_valid == 1'b0, "R11", "out_valid in reset", out_valid, 0);
      @(posedge clk); #2;
      rst_n = 1;
      next_cycle();
      chk(out_valid == 1'b0, "R11", "out_valid after reset", out_valid, 0);

      // R11, R8: empty table gives the default route
      send(32'h0A010203, "R11");
      send(32'hC8000001, "R8");
      drain();

      // level 1: /4 for 0.0.0.0 and /8 for 10.0.0.0
      wr(1, 1, 1, 24'h000000, pfx(4, 0) | pfx(8, 10), 100);
      send(32'h0A010203, "R5");   // longest in level: /8, idx 100+255+10
      send(32'h0C000001, "R5");   // only /4, idx 100+15
      send(32'hC8000001, "R8");   // nothing
      drain();

      // level 2: junk low tag bits, /16 for 10.1 and /9 for 10.0-10.127
      wr(2, 2, 1, 24'h0AFFFF, pfx(8, 1) | pfx(1, 0), 1000);
      send(32'h0A010505, "R2");   // /16, idx 1256
      send(32'h0A01FFFF, "R2");   // low bits do not matter
      send(32'h0A020505, "R3");   // /9, idx 1001
      send(32'h0B010505, "R4");   // level-2 tag misses, falls back to /4
      // level 3: /24 for 10.1.7
      wr(3, 3, 1, 24'h0A0100, pfx(8, 7), 3000);
      send(32'h0A010709, "R3");   // /24, idx 3262
      send(32'h0A010809, "R3");   // no /24, /16 remains
      // level 4: /32 for 10.1.5.5
      wr(4, 0, 1, 24'h0A0105, pfx(8, 5), 2000);
      send(32'h0A010505, "R7");   // /32, idx 2260
      send(32'h0A010506, "R7");   // /16
      send(32'h0A010505, "R6");
      drain();

      // R10: remove and rewrite entries
      wr(4, 0, 0, 24'h0A0105, pfx(8, 5), 2000);
      send(32'h0A010505, "R10");  // /32 gone, /16 left
      wr(1, 1, 1, 24'h000000, pfx(8, 12), 500);
      send(32'h0C000001, "R10");  // /8, idx 500+267
      send(32'h0E000001, "R10");  // /4 gone
      drain();

      // R1: back-to-back burst with ready held high
      begin
         int c0;
         lat_mode = 1;
         c0 = cyc;
         for (int k = 0; k < 8; k++) send(32'h0A010500 + 32'(k), "R1");
         chk(cyc - c0 == 8, "R1", "one accept per cycle", cyc - c0, 8);
         drain();
         lat_mode = 0;
      end

      // R9: consumer holds off
      out_ready = 0;
      send(32'h0A010709, "R9");
      send(32'h0A020000, "R9");
      repeat (8) next_cycle();
      out_ready = 1;
      drain();

      // R7: random addresses near stored prefixes, random backpressure and rewrites
      rr_mode = 1;
      for (int b = 0; b < 5; b++) begin
         begin
            int lv; int sl; logic [509:0] bm; logic [31:0] ba;
            lv = $urandom_range(4, 1);
            sl = $urandom_range(3, 0);
            ba = bases[$urandom_range(3, 0)];
            bm = '0;
            for (int k = 0; k < 6; k++) begin
               int l;
               l = $urandom_range(8, 1);
               bm = bm | pfx(l, $urandom_range((1 << l) - 1, 0));
            end
            wr(lv, sl, ($urandom_range(4) != 0), ba[31:8], bm, $urandom_range(20000, 0));
         end
         for (int k = 0; k < 60; k++) begin
            logic [31:0] a; logic [31:0] m;
            case ($urandom_range(3, 0))
               0: m = 32'h000000FF;
               1: m = 32'h0000FFFF;
               2: m = 32'h00FFFFFF;
               default: m = 32'hFFFFFFFF;
            endcase
            a = bases[$urandom_range(3, 0)] ^ ($urandom & m);
            send(a, "R7");
         end
         rr_mode = 0;
         out_ready = 1;
         drain();
         rr_mode = 1;
      end
      rr_mode = 0;
      out_ready = 1;
      drain();

      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_checks++;
         n_fail++;
         $display("FAIL R1 watchdog: got %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
         $finish;
      end
   end

endmodule